// File: doc/BRIEF.md
# Scan-Driven System Bus Access Controller

This block connects a decoded test access port to an on-chip system bus. Each update strobe from the scan chain, together with the selected instruction and the scanned fields, becomes a single-beat bus read or write. The block keeps track of whether the next data-register scan holds an address or data. It reports a busy flag and an error flag in the low bits of every captured data word. The host uses the busy flag to decide whether to repeat a scan.

There are four instructions. Single access takes an address scan and then a data scan. Block access needs only one data scan per transfer, because the address steps forward by the access size after each successful transfer. Sync holds busy for a scanned number of cycles. Cancel aborts a stalled bus access. Every access is checked for legality before it is issued, and an illegal access ends locally with the error flag set. The check looks at the address window, the read-only region, alignment to the access size, and a protected-mode window. The `WORD_ONLY` parameter selects a variant of the check that also rejects byte and halfword sizes.

Top module: `scan_bus_bridge`

## Requirements
- R1: After reset, a captured word is all zero, the phase is address (`in_data_phase` = 0), and `bus_req` is low.
- R2: Single read. `instr` = 0 with `upd_dr` in the address phase and `scan_rd` = 1 raises `bus_req` one cycle later, at the scanned address with `bus_we` = 0, and moves to the data phase. When `bus_ack` arrives, busy clears. An `upd_dr` in the data phase while idle then returns the phase to address.
- R3: Single write. An address-phase `upd_dr` with `scan_rd` = 0 moves to the data phase and makes no bus request. The next data-phase `upd_dr` issues a write of `scan_wdata` to that address. Completion of that write returns the phase to address.
- R4: While busy, every `upd_dr` is dropped with no effect. In the address phase the address is discarded and the phase stays address. In the data phase the write data is discarded and the phase stays data. Read data captured while busy carries busy = 1.
- R5: Block access (`instr` = 1). Each idle `upd_dr` starts a transfer at the current address in the stored direction, and the phase stays data. After each error-free completion the address advances by 1, 2 or 4 (size code 0, 1, 2). After an error completion it does not advance.
- R6: An idle `upd_ir` with `instr` = 1 issues a read at the advanced address. This happens only when the last access was a read and its data scan has already taken place.
- R7: Sync (`instr` = 3). An idle `upd_dr` holds busy for max(N,1) cycles, where N is `scan_count`.
- R8: An `upd_ir` with `instr` = 2 cancels any operation. One cycle later `bus_req` is low, busy and error are 0, the phase is address, and the address is unchanged.
- R9: The error flag clears when an access starts. At completion it takes the value of `bus_err`.
- R10: Some accesses are illegal and issue no bus request: size code 3, an address misaligned to its size, an address at or above `MAP_TOP`, a write at or above `RO_BASE`, or, with `prot_mode` high, an address at or above `OPEN_TOP`. Such an access completes one cycle after it starts, with error = 1.
- R11: `cap_dr` loads `cap_word` one cycle later. Bit 0 is busy, bit 1 is error, and bits DW+1..2 hold the data of the last read.
- R12: Once raised, `bus_req` stays high with a stable address, direction and data until `bus_ack` arrives or a cancel occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_dr | input | 1 | Data-register update strobe |
| upd_ir | input | 1 | Instruction-register update strobe |
| cap_dr | input | 1 | Data-register capture strobe |
| instr | input | 2 | Selected instruction: 0 single, 1 block, 2 cancel, 3 sync |
| scan_addr | input | AW | Scanned address |
| scan_rd | input | 1 | Scanned direction, 1 = read |
| scan_size | input | 2 | Scanned size: 0 byte, 1 half, 2 word, 3 reserved |
| scan_wdata | input | DW | Scanned write data |
| scan_count | input | CW | Scanned sync count |
| prot_mode | input | 1 | Protected mode, narrows the legal window |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | AW | Bus address |
| bus_size | output | 2 | Bus access size code |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Bus completion |
| bus_err | input | 1 | Bus error, valid with bus_ack |
| bus_rdata | input | DW | Bus read data, valid with bus_ack |
| cap_word | output | DW+2 | Captured word: read data, error, busy |
| in_data_phase | output | 1 | 1 when the next single scan is data |

## Verification
The request is due at the first edge after an update strobe. A zero-latency slave completes the transfer at the edge after that. A capture strobe shows the status held before its own edge, so a capture taken straight after an update still reads busy. For sync, busy stays high for exactly N edges. The bench drives strobes for one clock, samples on falling edges, and reads results after fixed margins of three or four cycles that cover these counts. The sync length is measured by capturing on every cycle and counting the busy samples.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
   typedef enum logic [1:0] {
      OP_SINGLE = 2'd0,
      OP_BLOCK  = 2'd1,
      OP_CANCEL = 2'd2,
      OP_SYNC   = 2'd3
   } sbb_op_e;
endpackage

// File: rtl/sbb_addr_ptr.sv
module sbb_addr_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step_en,
   input  logic [1:0]    step_size,
   output logic [AW-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= '0;
      else if (load)    addr <= load_val;
      else if (step_en) addr <= addr + (AW'(1) << step_size);
   end
endmodule

// File: rtl/sbb_access_check.sv
module sbb_access_check #(
   parameter int          AW        = 16,
   parameter logic [AW:0] MAP_TOP   = 'hE000,
   parameter logic [AW:0] RO_BASE   = 'hC000,
   parameter logic [AW:0] OPEN_TOP  = 'h4000,
   parameter bit          WORD_ONLY = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic          is_read,
   input  logic [1:0]    size,
   input  logic          prot,
   output logic          illegal
);
   logic bad_size, misalign, out_map, ro_hit, prot_hit;

   if (WORD_ONLY) begin : g_word_only
      assign bad_size = (size != 2'd2);
   end else begin : g_any_size
      assign bad_size = (size == 2'd3);
   end

   always_comb begin
      case (size)
         2'd1:    misalign = addr[0];
         2'd2:    misalign = |addr[1:0];
         default: misalign = 1'b0;
      endcase
   end

   assign out_map  = {1'b0, addr} >= MAP_TOP;
   assign ro_hit   = !is_read && ({1'b0, addr} >= RO_BASE);
   assign prot_hit = prot && ({1'b0, addr} >= OPEN_TOP);
   assign illegal  = bad_size | misalign | out_map | ro_hit | prot_hit;
endmodule

// File: rtl/sbb_sync_timer.sv
module sbb_sync_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] count,
   input  logic          abort,
   output logic          running
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt_q   <= '0;
      end else if (abort) begin
         running <= 1'b0;
      end else if (load) begin
         running <= 1'b1;
         cnt_q   <= count;
      end else if (running) begin
         if (cnt_q < CW'(2)) running <= 1'b0;
         else                cnt_q   <= cnt_q - 1'b1;
      end
   end

   // R7
   sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !abort && !load && (cnt_q > CW'(1)) |=> running);
endmodule

// File: rtl/scan_bus_bridge.sv
module scan_bus_bridge #(
   parameter int          AW        = 16,
   parameter int          DW        = 32,
   parameter int          CW        = 8,
   parameter logic [AW:0] MAP_TOP   = 'hE000,
   parameter logic [AW:0] RO_BASE   = 'hC000,
   parameter logic [AW:0] OPEN_TOP  = 'h4000,
   parameter bit          WORD_ONLY = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_dr,
   input  logic          upd_ir,
   input  logic          cap_dr,
   input  logic [1:0]    instr,
   input  logic [AW-1:0] scan_addr,
   input  logic          scan_rd,
   input  logic [1:0]    scan_size,
   input  logic [DW-1:0] scan_wdata,
   input  logic [CW-1:0] scan_count,
   input  logic          prot_mode,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [1:0]    bus_size,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic          bus_err,
   input  logic [DW-1:0] bus_rdata,
   output logic [DW+1:0] cap_word,
   output logic          in_data_phase
);
   import sbb_pkg::*;

   localparam int CAPW = DW + 2;

   if (AW < 2 || AW > 62) begin : g_bad_aw
      $error("scan_bus_bridge: AW out of range");
   end
   if (DW < 1 || CW < 1) begin : g_bad_width
      $error("scan_bus_bridge: DW and CW must be positive");
   end
   if (MAP_TOP > ((AW+1)'(1) << AW) || RO_BASE > MAP_TOP) begin : g_bad_map
      $error("scan_bus_bridge: address window parameters inconsistent");
   end

   sbb_op_e op;
   assign op = sbb_op_e'(instr);

   logic          req_q, acc_busy, fail_q, err_q, phase_q, rd_q, rd_seen, blk_acc;
   logic [1:0]    size_q;
   logic [DW-1:0] wdata_q, rdata_q;
   logic [CAPW-1:0] cap_q;
   logic [AW-1:0] addr_q;
   logic          sync_run, busy, idle, cancel_hit;
   logic          sgl_addr, sgl_data, blk_dr, blk_ir, sync_go, start, load_wd, done_bus;
   logic [AW-1:0] chk_addr;
   logic          chk_rd, illegal;
   logic [1:0]    chk_size;

   assign busy       = acc_busy | sync_run;
   assign idle       = !busy;
   assign cancel_hit = upd_ir && (op == OP_CANCEL);
   assign sgl_addr   = upd_dr && (op == OP_SINGLE) && !phase_q && idle;
   assign sgl_data   = upd_dr && (op == OP_SINGLE) &&  phase_q && idle;
   assign blk_dr     = upd_dr && (op == OP_BLOCK) && idle;
   assign blk_ir     = upd_ir && (op == OP_BLOCK) && idle && rd_q && rd_seen;
   assign sync_go    = upd_dr && (op == OP_SYNC) && idle;
   assign start      = (sgl_addr && scan_rd) || (sgl_data && !rd_q) || blk_dr || blk_ir;
   assign load_wd    = (sgl_data || blk_dr) && !rd_q;
   assign done_bus   = req_q && bus_ack;

   assign chk_addr = sgl_addr ? scan_addr : addr_q;
   assign chk_rd   = sgl_addr ? scan_rd   : rd_q;
   assign chk_size = sgl_addr ? scan_size : size_q;

   sbb_access_check #(
      .AW(AW), .MAP_TOP(MAP_TOP), .RO_BASE(RO_BASE),
      .OPEN_TOP(OPEN_TOP), .WORD_ONLY(WORD_ONLY)
   ) u_check (
      .addr(chk_addr), .is_read(chk_rd), .size(chk_size),
      .prot(prot_mode), .illegal(illegal)
   );

   sbb_addr_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(sgl_addr && !cancel_hit), .load_val(scan_addr),
      .step_en(done_bus && !bus_err && !cancel_hit), .step_size(size_q), .addr(addr_q)
   );

   sbb_sync_timer #(.CW(CW)) u_sync (
      .clk(clk), .rst_n(rst_n), .load(sync_go && !cancel_hit),
      .count(scan_count), .abort(cancel_hit), .running(sync_run)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0; acc_busy <= 1'b0; fail_q <= 1'b0; err_q <= 1'b0;
         phase_q <= 1'b0; rd_q <= 1'b0; rd_seen <= 1'b0; blk_acc <= 1'b0;
         size_q <= '0; wdata_q <= '0;
      end else if (cancel_hit) begin
         req_q <= 1'b0; acc_busy <= 1'b0; fail_q <= 1'b0; err_q <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         if (sgl_addr) begin
            rd_q <= scan_rd; size_q <= scan_size; phase_q <= 1'b1; rd_seen <= 1'b0;
         end
         if (sgl_data && rd_q) begin
            phase_q <= 1'b0; rd_seen <= 1'b1;
         end
         if (blk_dr) phase_q <= 1'b1;
         if (load_wd) wdata_q <= scan_wdata;
         if (start) begin
            acc_busy <= 1'b1;
            err_q    <= 1'b0;
            blk_acc  <= (op == OP_BLOCK);
            if (illegal) fail_q <= 1'b1;
            else         req_q  <= 1'b1;
         end
         if (fail_q) begin
            fail_q <= 1'b0; acc_busy <= 1'b0; err_q <= 1'b1;
            if (!blk_acc && !rd_q) phase_q <= 1'b0;
         end
         if (done_bus) begin
            req_q <= 1'b0; acc_busy <= 1'b0; err_q <= bus_err;
            if (!blk_acc && !rd_q) phase_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         cap_q   <= '0;
      end else begin
         if (done_bus && rd_q) rdata_q <= bus_rdata;
         if (cap_dr) cap_q <= {rdata_q, err_q, busy};
      end
   end

   assign bus_req       = req_q;
   assign bus_we        = !rd_q;
   assign bus_addr      = addr_q;
   assign bus_size      = size_q;
   assign bus_wdata     = wdata_q;
   assign cap_word      = cap_q;
   assign in_data_phase = phase_q;

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack && !cancel_hit |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
   // R8
   cancel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_hit |=> !bus_req && !busy && !err_q && !in_data_phase && $stable(bus_addr));
   // R4
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_dr && busy && !cancel_hit && !done_bus && !fail_q |=> $stable(in_data_phase) && $stable(bus_addr) && $stable(bus_wdata));
   // R9
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !cancel_hit |=> !err_q && busy);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_bus && !cancel_hit |=> !bus_req && !acc_busy);
   // R10
   fail_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q && !cancel_hit |=> err_q && !bus_req);
endmodule

// File: tb/scan_bus_bridge_bench.sv
module scan_bus_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_dr = 1'b0, upd_ir = 1'b0, cap_dr = 1'b0;
   logic [1:0]  instr = 2'd0;
   logic [15:0] scan_addr = '0;
   logic        scan_rd = 1'b0;
   logic [1:0]  scan_size = 2'd0;
   logic [31:0] scan_wdata = '0;
   logic [7:0]  scan_count = '0;
   logic        prot_mode = 1'b0;
   logic        bus_req, bus_we;
   logic [15:0] bus_addr;
   logic [1:0]  bus_size;
   logic [31:0] bus_wdata, bus_rdata;
   logic        bus_ack = 1'b0;
   logic        bus_err;
   logic [33:0] cap_word;
   logic        in_data_phase;

   int tests = 0, fails = 0;
   int lat = 0, scnt = 0, req_seen = 0;
   logic err_mode = 1'b0;
   logic [15:0] wr_a = '0;
   logic [31:0] wr_d = '0;

   always #2.5 clk = ~clk;

   assign bus_rdata = {~bus_addr, bus_addr};
   assign bus_err   = bus_ack & err_mode;

   scan_bus_bridge u_scan_bus_bridge (
      .clk(clk), .rst_n(rst_n), .upd_dr(upd_dr), .upd_ir(upd_ir), .cap_dr(cap_dr),
      .instr(instr), .scan_addr(scan_addr), .scan_rd(scan_rd), .scan_size(scan_size),
      .scan_wdata(scan_wdata), .scan_count(scan_count), .prot_mode(prot_mode),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
      .cap_word(cap_word), .in_data_phase(in_data_phase)
   );

   always @(negedge clk) begin
      if (bus_req) req_seen++;
      if (bus_ack) begin
         bus_ack <= 1'b0;
         scnt = 0;
      end else if (bus_req) begin
         if (scnt >= lat) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
               wr_a <= bus_addr;
               wr_d <= bus_wdata;
            end
         end else scnt++;
      end else scnt = 0;
   end

   typedef struct packed {
      logic        rd;
      logic [1:0]  sz;
      logic [15:0] a;
      logic [31:0] wd;
      logic [31:0] rx;
      logic        er;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b1, 2'd2, 16'h0100, 32'h0,        32'hFEFF0100, 1'b0},
      '{1'b0, 2'd2, 16'h0200, 32'hDEADBEEF, 32'h0,        1'b0},
      '{1'b1, 2'd1, 16'h0202, 32'h0,        32'hFDFD0202, 1'b0},
      '{1'b1, 2'd1, 16'h0203, 32'h0,        32'h0,        1'b1},
      '{1'b0, 2'd0, 16'hC001, 32'h55,       32'h0,        1'b1},
      '{1'b1, 2'd0, 16'hC001, 32'h0,        32'h3FFEC001, 1'b0},
      '{1'b1, 2'd2, 16'hE000, 32'h0,        32'h0,        1'b1},
      '{1'b1, 2'd3, 16'h0000, 32'h0,        32'h0,        1'b1}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dr(input logic [1:0] op, input logic [15:0] a, input logic rd,
                     input logic [1:0] sz, input logic [31:0] wd, input logic [7:0] cnt);
      instr = op; scan_addr = a; scan_rd = rd; scan_size = sz;
      scan_wdata = wd; scan_count = cnt; upd_dr = 1'b1;
      @(negedge clk);
      upd_dr = 1'b0;
   endtask

   task automatic ir(input logic [1:0] op);
      instr = op; upd_ir = 1'b1;
      @(negedge clk);
      upd_ir = 1'b0;
   endtask

   task automatic cap(output logic [33:0] w);
      cap_dr = 1'b1;
      @(negedge clk);
      cap_dr = 1'b0;
      w = cap_word;
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (400) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [33:0] w;
      int seen0, ones;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      cap(w);
      chk("R1 capture after reset", w, 34'h0);
      chk("R1 phase after reset", in_data_phase, 1'b0);
      chk("R1 bus_req after reset", bus_req, 1'b0);

      // R10 R9 R11 vector table of single accesses
      for (int i = 0; i < 8; i++) begin
         seen0 = req_seen;
         dr(2'd0, VECS[i].a, VECS[i].rd, VECS[i].sz, 32'h0, 8'd0);
         if (!VECS[i].rd) dr(2'd0, 16'h0, 1'b0, 2'd0, VECS[i].wd, 8'd0);
         tick(4);
         cap(w);
         chk($sformatf("R10 vec%0d error bit", i), w[1], VECS[i].er);
         chk($sformatf("R11 vec%0d busy bit", i), w[0], 1'b0);
         if (VECS[i].er)
            chk($sformatf("R10 vec%0d no bus request", i), req_seen - seen0, 0);
         else if (VECS[i].rd)
            chk($sformatf("R11 vec%0d read data", i), w[33:2], VECS[i].rx);
         else begin
            chk($sformatf("R3 vec%0d write addr", i), wr_a, VECS[i].a);
            chk($sformatf("R3 vec%0d write data", i), wr_d, VECS[i].wd);
         end
         if (VECS[i].rd) dr(2'd0, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
         chk($sformatf("R2 vec%0d phase back to address", i), in_data_phase, 1'b0);
      end

      // R2 R4 R12 single read with slow slave
      lat = 3;
      dr(2'd0, 16'h0040, 1'b1, 2'd2, 32'h0, 8'd0);
      chk("R2 request one cycle after update", bus_req, 1'b1);
      chk("R2 request address", bus_addr, 16'h0040);
      chk("R2 read direction", bus_we, 1'b0);
      chk("R2 data phase", in_data_phase, 1'b1);
      cap(w);
      chk("R4 read capture while busy flags busy", w[0], 1'b1);
      dr(2'd0, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      chk("R4 data scan while busy keeps data phase", in_data_phase, 1'b1);
      chk("R12 request held", bus_req, 1'b1);
      chk("R12 address held", bus_addr, 16'h0040);
      tick(4);
      cap(w);
      chk("R11 busy clear after completion", w[1:0], 2'b00);
      chk("R11 read data field", w[33:2], 32'hFFBF0040);
      dr(2'd0, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      chk("R2 data scan returns phase", in_data_phase, 1'b0);
      lat = 0;

      // R4 address dropped while busy
      dr(2'd3, 16'h0, 1'b0, 2'd0, 32'h0, 8'd8);
      seen0 = req_seen;
      dr(2'd0, 16'h0300, 1'b1, 2'd2, 32'h0, 8'd0);
      chk("R4 address while busy no request", bus_req, 1'b0);
      chk("R4 address while busy phase stays", in_data_phase, 1'b0);
      tick(12);
      chk("R4 dropped address never reached bus", req_seen - seen0, 0);

      // R3 R4 write data dropped while busy
      dr(2'd0, 16'h0500, 1'b0, 2'd2, 32'h0, 8'd0);
      chk("R3 write address scan enters data phase", in_data_phase, 1'b1);
      chk("R3 write address scan no request", bus_req, 1'b0);
      dr(2'd3, 16'h0, 1'b0, 2'd0, 32'h0, 8'd20);
      dr(2'd0, 16'h0, 1'b0, 2'd0, 32'hAAAA5555, 8'd0);
      chk("R4 write while busy phase stays data", in_data_phase, 1'b1);
      chk("R4 write while busy no request", bus_req, 1'b0);
      tick(25);
      dr(2'd0, 16'h0, 1'b0, 2'd0, 32'h12345678, 8'd0);
      chk("R3 write request", bus_req, 1'b1);
      chk("R3 write enable", bus_we, 1'b1);
      chk("R3 write address", bus_addr, 16'h0500);
      chk("R3 write data", bus_wdata, 32'h12345678);
      tick(3);
      chk("R3 phase back after write", in_data_phase, 1'b0);

      // R7 sync length
      dr(2'd3, 16'h0, 1'b0, 2'd0, 32'h0, 8'd5);
      ones = 0;
      cap_dr = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (cap_word[0]) ones++;
      end
      cap_dr = 1'b0;
      chk("R7 sync busy cycles for N=5", ones, 5);
      dr(2'd3, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      ones = 0;
      cap_dr = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (cap_word[0]) ones++;
      end
      cap_dr = 1'b0;
      chk("R7 sync busy cycles for N=0", ones, 1);

      // R5 block writes with halfword stepping
      dr(2'd0, 16'h0600, 1'b0, 2'd1, 32'h0, 8'd0);
      dr(2'd0, 16'h0, 1'b0, 2'd0, 32'h11110000, 8'd0);
      tick(3);
      dr(2'd1, 16'h0, 1'b0, 2'd0, 32'h22220000, 8'd0);
      tick(3);
      chk("R5 block write address", wr_a, 16'h0602);
      chk("R5 block write data", wr_d, 32'h22220000);
      chk("R5 block keeps data phase", in_data_phase, 1'b1);
      dr(2'd1, 16'h0, 1'b0, 2'd0, 32'h33330000, 8'd0);
      tick(3);
      chk("R5 block second write address", wr_a, 16'h0604);
      ir(2'd2);
      chk("R8 cancel returns phase", in_data_phase, 1'b0);

      // R6 prefetch on instruction update
      dr(2'd0, 16'h0700, 1'b1, 2'd2, 32'h0, 8'd0);
      tick(3);
      cap(w);
      chk("R2 single read data", w[33:2], 32'hF8FF0700);
      dr(2'd0, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      ir(2'd1);
      chk("R6 prefetch request", bus_req, 1'b1);
      chk("R6 prefetch address", bus_addr, 16'h0704);
      chk("R6 prefetch is read", bus_we, 1'b0);
      tick(3);
      cap(w);
      chk("R6 prefetch data", w[33:2], 32'hF8FB0704);
      dr(2'd1, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      chk("R5 block read word step", bus_addr, 16'h0708);
      tick(3);

      // R9 bus error, then R8 cancel of a hung access
      err_mode = 1'b1;
      dr(2'd1, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      chk("R5 block read address", bus_addr, 16'h070C);
      tick(3);
      err_mode = 1'b0;
      cap(w);
      chk("R9 bus error sets error bit", w[1:0], 2'b10);
      lat = 1000;
      dr(2'd1, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      chk("R5 no step after error", bus_addr, 16'h070C);
      cap(w);
      chk("R9 error cleared at start", w[1:0], 2'b01);
      ir(2'd2);
      chk("R8 cancel drops request", bus_req, 1'b0);
      chk("R8 cancel phase address", in_data_phase, 1'b0);
      cap(w);
      chk("R8 cancel clears busy and error", w[1:0], 2'b00);
      lat = 0;
      dr(2'd1, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      chk("R8 address kept after cancel", bus_addr, 16'h070C);
      tick(3);
      ir(2'd2);

      // R10 protected window
      prot_mode = 1'b1;
      seen0 = req_seen;
      dr(2'd0, 16'h4000, 1'b1, 2'd2, 32'h0, 8'd0);
      tick(3);
      cap(w);
      chk("R10 protected read outside window errors", w[1], 1'b1);
      chk("R10 protected read issued nothing", req_seen - seen0, 0);
      dr(2'd0, 16'h0, 1'b0, 2'd0, 32'h0, 8'd0);
      dr(2'd0, 16'h3FFC, 1'b1, 2'd2, 32'h0, 8'd0);
      tick(3);
      cap(w);
      chk("R10 protected read inside window ok", w[1], 1'b0);
      chk("R11 protected read data", w[33:2], 32'hC0033FFC);
      prot_mode = 1'b0;

      summary();
      $finish;
   end
endmodule